// File: doc/BRIEF.md
# Sampling Tap Window Selector

After a tuning sweep, this block chooses the sampling-phase tap for a high-speed card interface. Each of N delay taps is probed twice, and the results arrive as one pass/fail map of 2N bits. The lower N bits hold the first sweep and the upper N bits hold the second sweep of the same taps. The block first folds the two sweeps together, so that a tap is good only when it passed in both. It then walks the merged 2N-bit map one position per clock, looking for the longest stretch of consecutive good positions. A window that runs across the wrap point of the tap ring is therefore found as one run. The block reports the centre of the winning window, reduced modulo N. If no window is long enough, it reports an error instead.

The tap count is 8 for the single-data-rate modes and 4 for the double-data-rate mode. The `ddr_mode` input selects it, and its value is captured together with the map when a scan is accepted. After a successful selection, the block drives the chosen tap and raises an enable for automatic re-tune error detection.

Top module: `tap_window_sel`

## Requirements
- R1: A tap counts as good only if its bit is 1 in both sweeps: bit i and bit i+N of `pass_map` for i < N. A failure in either sweep removes the tap from both copies.
- R2: The search covers all 2N merged positions in order 0 to 2N-1 and finds the longest run of consecutive good positions. This includes a run that ends at position 2N-1.
- R3: When several runs share the greatest length, the one that starts earliest is chosen.
- R4: If the longest run is shorter than MIN_RUN (default 3), the scan ends with `tap_err`=1 and `tap_valid`=0, and `tap_sel` keeps its previous value.
- R5: Otherwise `tap_sel` = ((start + end) / 2) mod N, where start and end are the first and last positions of the winning run and the division rounds down.
- R6: With `ddr_mode`=0 at the accepting edge, N = MAX_TAPS (8). With `ddr_mode`=1, N = MAX_TAPS/2 (4). In that case `pass_map` bits at and above 2N are ignored.
- R7: `retune_en` goes to 1 on a successful selection, clears when a new scan is accepted, and stays 0 when a scan ends in error.
- R8: A scan is accepted on a clock edge where `start`=1 and `busy`=0. `busy` then stays 1 for 2N+1 cycles, and `done` pulses for exactly one cycle 2N+1 edges after the accepting edge. With `done`, exactly one of `tap_valid` and `tap_err` is 1. Both flags hold until the next accepted scan.
- R9: A `start` pulse while `busy`=1 is ignored: it does not restart the scan, change its result, or produce an extra `done`.
- R10: After a synchronous reset (`rst_n`=0), `busy`, `done`, `tap_valid`, `tap_err`, `retune_en` are 0 and `tap_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| ddr_mode | input | 1 | 1 selects MAX_TAPS/2 taps, 0 selects MAX_TAPS |
| pass_map | input | 2*MAX_TAPS | Two-sweep pass/fail map, first sweep in the low half |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| tap_valid | output | 1 | Last scan produced a tap |
| tap_err | output | 1 | Last scan found no usable window |
| tap_sel | output | $clog2(MAX_TAPS) | Selected sampling tap |
| retune_en | output | 1 | Automatic re-tune error detection enable |

## Verification
The maps used separate the search's individual decisions:
- An all-pass map produces a run that reaches the last position, so it fails unless the trailing run is closed.
- A map where one sweep passes everywhere and the other fails everywhere shows the merge at work.
- Four equal three-tap windows distinguish earliest-wins from latest-wins, since the two choices give taps 1 and 5.
- Windows of exactly two and exactly three taps sit on either side of the minimum length.
- Windows that straddle the tap wrap point yield a centre of N or more, which exposes a missing reduction in both tap counts.
- A second start issued during a scan, and garbage in the unused upper map bits in the four-tap mode, confirm that both are ignored.

// File: rtl/tapsel_pkg.sv
// Shared types for the sampling tap window selector.
package tapsel_pkg;

    // Scan controller state
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_e;

endpackage

// File: rtl/tapsel_merge.sv
// Merges the two probe sweeps of the tap ring. A tap stays good only when
// it passed in both sweeps, and the result is mirrored into both halves of
// the map. Assumes MAX_TAPS is even. In the half-count mode the bits at and
// above 2*(MAX_TAPS/2) read as zero.
module tapsel_merge #(
    parameter int MAX_TAPS = 8
) (
    input  logic                  ddr_mode,
    input  logic [2*MAX_TAPS-1:0] raw_map,
    output logic [2*MAX_TAPS-1:0] merged_map
);
    localparam int HALF = MAX_TAPS / 2;

    logic [2*MAX_TAPS-1:0] full_m;
    logic [2*MAX_TAPS-1:0] half_m;

    // Full tap count: sweep halves are MAX_TAPS bits wide
    for (genvar i = 0; i < MAX_TAPS; i++) begin : g_full
        assign full_m[i]            = raw_map[i] & raw_map[i+MAX_TAPS];
        assign full_m[i+MAX_TAPS]   = raw_map[i] & raw_map[i+MAX_TAPS];
    end

    // Half tap count: sweep halves are HALF bits wide, upper bits unused
    for (genvar i = 0; i < HALF; i++) begin : g_half
        assign half_m[i]        = raw_map[i] & raw_map[i+HALF];
        assign half_m[i+HALF]   = raw_map[i] & raw_map[i+HALF];
    end
    assign half_m[2*MAX_TAPS-1:MAX_TAPS] = '0;

    // Pick the merge matching the tap count
    assign merged_map = ddr_mode ? half_m : full_m;

endmodule

// File: rtl/tapsel_run_tracker.sv
// Tracks the longest run of ones seen so far, one bit per step. A later
// run replaces the best only when strictly longer, so ties keep the
// earliest run. The fin_* outputs fold in a run still open at position pos.
// This closes a run that reaches the last bit when pos is one past the end.
module tapsel_run_tracker #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] fin_start,
    output logic [IDX_W-1:0] fin_len
);
    logic [IDX_W-1:0] cur_len;
    logic [IDX_W-1:0] best_len;
    logic [IDX_W-1:0] best_start;

    // Update the current and best run on each scanned bit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_len    <= '0;
            best_len   <= '0;
            best_start <= '0;
        end else if (step) begin
            if (bit_in) begin
                cur_len <= cur_len + 1'b1;
            end else begin
                if (cur_len > best_len) begin
                    best_len   <= cur_len;
                    best_start <= pos - cur_len;
                end
                cur_len <= '0;
            end
        end
    end

    // Final view including a still-open run
    always_comb begin
        if (cur_len > best_len) begin
            fin_start = pos - cur_len;
            fin_len   = cur_len;
        end else begin
            fin_start = best_start;
            fin_len   = best_len;
        end
    end

endmodule

// File: rtl/tapsel_center.sv
// Computes the centre tap of a run: floor((start + end) / 2) mod N.
// Assumes MAX_TAPS is a power of two, so the modulo is a mask. N is
// MAX_TAPS, or MAX_TAPS/2 when ddr_mode is set.
module tapsel_center #(
    parameter int MAX_TAPS = 8,
    parameter int IDX_W    = 5,
    parameter int TAP_W    = 3
) (
    input  logic             ddr_mode,
    input  logic [IDX_W-1:0] run_start,
    input  logic [IDX_W-1:0] run_len,
    output logic [TAP_W-1:0] center_tap
);
    logic [IDX_W:0]   pos_sum;
    logic [IDX_W-1:0] mid_pos;
    logic [TAP_W-1:0] ring_mask;

    // start + end = 2*start + len - 1, then halve and wrap onto the ring
    always_comb begin
        pos_sum    = {1'b0, run_start} + {1'b0, run_start} + {1'b0, run_len}
                     - (IDX_W+1)'(1);
        mid_pos    = pos_sum[IDX_W:1];
        ring_mask  = ddr_mode ? TAP_W'(MAX_TAPS/2 - 1) : TAP_W'(MAX_TAPS - 1);
        center_tap = mid_pos[TAP_W-1:0] & ring_mask;
    end

endmodule

// File: rtl/tap_window_sel.sv
// Sampling tap window selector top. On an accepted start it captures the
// merged two-sweep map and the tap-count mode. It scans one position per
// clock, closes any trailing run in a final cycle, and then pulses done
// with either a centre tap or an error. Assumes MAX_TAPS is a power of
// two, at least 4.
module tap_window_sel #(
    parameter int MAX_TAPS = 8,
    parameter int MIN_RUN  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        ddr_mode,
    input  logic [2*MAX_TAPS-1:0]       pass_map,
    output logic                        busy,
    output logic                        done,
    output logic                        tap_valid,
    output logic                        tap_err,
    output logic [$clog2(MAX_TAPS)-1:0] tap_sel,
    output logic                        retune_en
);
    import tapsel_pkg::*;

    localparam int MAP_W = 2 * MAX_TAPS;
    localparam int IDX_W = $clog2(MAP_W + 1);
    localparam int SEL_W = $clog2(MAP_W);
    localparam int TAP_W = $clog2(MAX_TAPS);
    localparam logic [IDX_W-1:0] SPAN_FULL = IDX_W'(MAP_W);
    localparam logic [IDX_W-1:0] SPAN_HALF = IDX_W'(MAX_TAPS);
    localparam logic [IDX_W-1:0] MIN_LEN   = IDX_W'(MIN_RUN);

    scan_state_e       state;
    logic [MAP_W-1:0]  merged_now;
    logic [MAP_W-1:0]  merged_q;
    logic              ddr_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  span;
    logic              accept;
    logic              scan_step;
    logic [IDX_W-1:0]  fin_start;
    logic [IDX_W-1:0]  fin_len;
    logic [TAP_W-1:0]  center_tap;

    // Merge the two sweeps from the live inputs
    tapsel_merge #(.MAX_TAPS(MAX_TAPS)) u_merge (
        .ddr_mode   (ddr_mode),
        .raw_map    (pass_map),
        .merged_map (merged_now)
    );

    // Longest-run search over the captured map
    tapsel_run_tracker #(.IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .step      (scan_step),
        .bit_in    (merged_q[idx[SEL_W-1:0]]),
        .pos       (idx),
        .fin_start (fin_start),
        .fin_len   (fin_len)
    );

    // Centre of the winning run, folded onto the tap ring
    tapsel_center #(.MAX_TAPS(MAX_TAPS), .IDX_W(IDX_W), .TAP_W(TAP_W)) u_center (
        .ddr_mode   (ddr_q),
        .run_start  (fin_start),
        .run_len    (fin_len),
        .center_tap (center_tap)
    );

    // Decode handshake and scan length
    assign busy      = (state != ST_IDLE);
    assign accept    = (state == ST_IDLE) && start;
    assign scan_step = (state == ST_SCAN);
    assign span      = ddr_q ? SPAN_HALF : SPAN_FULL;

    // Scan controller and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            merged_q  <= '0;
            ddr_q     <= 1'b0;
            idx       <= '0;
            done      <= 1'b0;
            tap_valid <= 1'b0;
            tap_err   <= 1'b0;
            tap_sel   <= '0;
            retune_en <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        merged_q  <= merged_now;
                        ddr_q     <= ddr_mode;
                        idx       <= '0;
                        tap_valid <= 1'b0;
                        tap_err   <= 1'b0;
                        retune_en <= 1'b0;
                        state     <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (idx == span - 1'b1) begin
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    done <= 1'b1;
                    if (fin_len >= MIN_LEN) begin
                        tap_sel   <= center_tap;
                        tap_valid <= 1'b1;
                        retune_en <= 1'b1;
                    end else begin
                        tap_err   <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tapsel_checker.sv
// Property checker for tap_window_sel, attached by bind. It watches the
// handshake, the result flags and the scan latency. The latency is checked
// with a local cycle counter rather than a long delay.
module tapsel_checker #(
    parameter int MAX_TAPS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic                        done,
    input logic                        tap_valid,
    input logic                        tap_err,
    input logic [$clog2(MAX_TAPS)-1:0] tap_sel,
    input logic                        retune_en,
    input logic                        ddr_q
);
    localparam int CNT_W = $clog2(2 * MAX_TAPS + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;

    // Count busy cycles since the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (start && !busy) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tap_valid != tap_err));                               // R8
    AST_SCAN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == (ddr_q ? CNT_W'(MAX_TAPS + 1) : CNT_W'(2*MAX_TAPS + 1)))); // R8
    AST_ERR_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tap_err) |-> $stable(tap_sel));                        // R4
    AST_ERR_NO_RETUNE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tap_err) |-> !retune_en);                              // R7
    AST_GOOD_RETUNE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tap_valid) |-> retune_en);                             // R7
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));                            // R9
    AST_HALF_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tap_valid && ddr_q) |-> (int'(tap_sel) < MAX_TAPS/2)); // R6

endmodule

bind tap_window_sel tapsel_checker #(.MAX_TAPS(MAX_TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .tap_valid (tap_valid),
    .tap_err   (tap_err),
    .tap_sel   (tap_sel),
    .retune_en (retune_en),
    .ddr_q     (ddr_q)
);

// File: tb/tb_tap_window_sel.sv
// Directed bench for tap_window_sel: one task per scenario, each checking
// its own results at the ports. Inputs change and outputs are sampled on
// the falling clock edge.
module tb_tap_window_sel;
    localparam int MAX_TAPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ddr_mode = 1'b0;
    logic [15:0] pass_map = '0;
    logic        busy, done, tap_valid, tap_err, retune_en;
    logic [2:0]  tap_sel;

    int n_checks = 0;
    int n_errors = 0;

    tap_window_sel #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ddr_mode(ddr_mode),
        .pass_map(pass_map), .busy(busy), .done(done), .tap_valid(tap_valid),
        .tap_err(tap_err), .tap_sel(tap_sel), .retune_en(retune_en)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Record one comparison
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Start one scan and wait for done; returns falling edges waited (-1 on timeout)
    task automatic run_scan(input logic [15:0] m, input logic ddr, output int lat);
        @(negedge clk);
        pass_map = m; ddr_mode = ddr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (!done) lat = -1;
    endtask

    // Scan and compare a successful result and its latency
    task automatic expect_tap(input string req, input logic [15:0] m, input logic ddr, input int exp_tap);
        int lat;
        run_scan(m, ddr, lat);
        chk(req, "latency", lat, ddr ? 2*4 + 2 : 2*8 + 2);
        chk(req, "tap_valid", int'(tap_valid), 1);
        chk(req, "tap_err", int'(tap_err), 0);
        chk(req, "tap_sel", int'(tap_sel), exp_tap);
        chk("R7", "retune_en on success", int'(retune_en), 1);
    endtask

    // Scan and compare an error result; tap must keep prior value
    task automatic expect_err(input string req, input logic [15:0] m, input logic ddr, input int prior_tap);
        int lat;
        run_scan(m, ddr, lat);
        chk(req, "done seen", int'(lat > 0), 1);
        chk(req, "tap_err", int'(tap_err), 1);
        chk(req, "tap_valid", int'(tap_valid), 0);
        chk("R4", "tap_sel held", int'(tap_sel), prior_tap);
        chk("R7", "retune_en on error", int'(retune_en), 0);
    endtask

    task automatic t_reset();
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "done", int'(done), 0);
        chk("R10", "tap_valid", int'(tap_valid), 0);
        chk("R10", "tap_err", int'(tap_err), 0);
        chk("R10", "tap_sel", int'(tap_sel), 0);
        chk("R10", "retune_en", int'(retune_en), 0);
    endtask

    // All pass: run 0..15 reaches the last bit, centre 7
    task automatic t_all_pass();
        expect_tap("R2", 16'hFFFF, 1'b0, 7);
        @(negedge clk);
        chk("R8", "done one cycle", int'(done), 0);
        chk("R8", "tap_valid held", int'(tap_valid), 1);
    endtask

    // First sweep passes, second fails: merged map empty
    task automatic t_merge();
        expect_err("R1", 16'h00FF, 1'b0, 7);
    endtask

    // Two-tap window rejected, three-tap window accepted (taps 3..5 -> 4)
    task automatic t_min_window();
        expect_err("R4", 16'h1818, 1'b0, 7);
        expect_tap("R4", 16'h3838, 1'b0, 4);
    endtask

    // Equal windows taps 0..2 and 4..6: earliest gives 1, latest would give 5
    task automatic t_tie();
        expect_tap("R3", 16'h7777, 1'b0, 1);
    endtask

    // Window 7,0,1 across wrap: positions 7..9, centre 8 mod 8 = 0
    task automatic t_wrap_full();
        expect_tap("R5", 16'h8383, 1'b0, 0);
    endtask

    // Half mode: all pass -> 3; taps 3,0,1 -> positions 3..5, centre 4 mod 4 = 0
    task automatic t_half_mode();
        expect_tap("R6", 16'h00FF, 1'b1, 3);
        expect_tap("R5", 16'h00BB, 1'b1, 0);
        expect_tap("R6", 16'hFFEE, 1'b1, 2);
    endtask

    // Second start during scan is ignored
    task automatic t_busy_start();
        int lat;
        int extra;
        @(negedge clk);
        pass_map = 16'h3838; ddr_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after accept", int'(busy), 1);
        repeat (3) @(negedge clk);
        pass_map = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 5;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", "latency from first start", lat, 18);
        chk("R9", "tap_sel from first map", int'(tap_sel), 4);
        extra = 0;
        repeat (30) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9", "extra done pulses", extra, 0);
        chk("R9", "busy after", int'(busy), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 20);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_pass();
        t_merge();
        t_min_window();
        t_tie();
        t_wrap_full();
        t_half_mode();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule